// File: doc/BRIEF.md
# Paged Program Counter with Circular Return Stack

This block produces the instruction fetch address for a small processor core. It holds a 13-bit program counter, a 5-bit page latch that supplies the upper counter bits, and an 8-deep by 13-bit return stack. Each cycle the instruction decoder raises at most one control strobe. The strobe selects one of these actions: advance to the next word, load the low byte with a computed value, take an absolute jump or call to an 11-bit target, enter an interrupt, or return through one of three return forms.

The counter's upper bits are never written directly. They come from the page latch, either in full on a low-byte write or as the top two bits on a jump or call. The return stack is a ring with no error reporting. When it overflows, the oldest entry is overwritten without notice. When it underflows, the pointer wraps and the pop returns whatever entry that slot holds. The fetch address is masked down to the implemented program memory, so addresses beyond it wrap. The memory size is a parameter of 1024 or 2048 words and defaults to 1024.

Top module: `page_pc_unit`

## Requirements
- R1: After reset, `fetchAddr` is 0x0000 and `pcLow` is 0x00, and the page latch and the stack pointer are zero.
- R2: `stepEn` increments the 13-bit counter by one. `fetchAddr` is the counter ANDed with (implemented words - 1). With the default of 1024 words, stepping from 0x3FF gives a fetch address of 0x000.
- R3: `lowWrEn` loads the counter with {page latch[4:0], `lowWrData`[7:0]}. The latch value used is the one held before the edge. `pcLow` always shows counter bits 7:0.
- R4: `jumpEn` loads the counter with {page latch[4:3], `jumpTarget`[10:0]}. Latch bits 2:0 have no effect on a jump.
- R5: `callEn` pushes the counter plus one onto the return stack and then loads the counter exactly as a jump does.
- R6: `irqEn` pushes the counter plus one and loads the counter with 0x0004.
- R7: `retPlainEn`, `retValueEn` and `retIrqEn` each pop the newest stack entry into the counter. No push or pop changes the page latch.
- R8: The stack holds 8 entries in a ring. A ninth push overwrites the first entry. After ten pushes, eight pops return the values of pushes 10 down to 3, in that order.
- R9: A pop from an empty stack wraps the pointer. It returns the entry stored in that slot and raises no error.
- R10: When several strobes are active in the same cycle, the action taken follows the priority interrupt > call > jump > return > low-byte write > step. With no strobe active, the counter holds its value.
- R11: `latchWrEn` loads the page latch from `latchWrData`, in parallel with any counter action. The latch value can be observed only through later low-byte writes and jumps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepEn | input | 1 | Sequential advance |
| lowWrEn | input | 1 | Computed write of the counter low byte |
| lowWrData | input | 8 | Low-byte value |
| latchWrEn | input | 1 | Load the page latch |
| latchWrData | input | 5 | Page latch value |
| jumpEn | input | 1 | Absolute jump |
| callEn | input | 1 | Call (push, then jump) |
| jumpTarget | input | 11 | Jump or call target from the instruction |
| irqEn | input | 1 | Interrupt entry |
| retPlainEn | input | 1 | Plain return |
| retValueEn | input | 1 | Return carrying a literal |
| retIrqEn | input | 1 | Return from interrupt |
| fetchAddr | output | 13 | Masked fetch address |
| pcLow | output | 8 | Counter bits 7:0 |

## Verification
The embedded properties assume that the interrupt priority logic and the decoder never raise conflicting strobes in a way the priority order does not resolve. Under that assumption, a jump always takes its page from the latch and a push always lands on top of the stack.

The stimulus mostly drives one strobe per cycle. A small share of cycles deliberately combine strobes to exercise the priority order. Directed cases add the tenth push, the pop past empty, and the wrap at the top of the implemented memory.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int PC_W    = 13;
  localparam int TGT_W   = 11;
  localparam int LATCH_W = PC_W - 8;
  localparam int LOW_W   = 8;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_STEP,
    OP_LOWWR,
    OP_JUMP,
    OP_CALL,
    OP_IRQ,
    OP_RET
  } pcOp_e;

  typedef struct packed {
    pcOp_e op;
    logic  push;
    logic  pop;
    logic  latchWr;
  } pcCtrl_t;
endpackage

// File: rtl/pc_ctrl.sv
module pc_ctrl
  import pc_pkg::*;
(
  input  logic    stepEn,
  input  logic    lowWrEn,
  input  logic    latchWrEn,
  input  logic    jumpEn,
  input  logic    callEn,
  input  logic    irqEn,
  input  logic    retPlainEn,
  input  logic    retValueEn,
  input  logic    retIrqEn,
  output pcCtrl_t ctrl
);
  logic anyRet;
  assign anyRet = retPlainEn | retValueEn | retIrqEn;

  always_comb begin
    ctrl = '{op: OP_HOLD, push: 1'b0, pop: 1'b0, latchWr: latchWrEn};
    if (irqEn)        ctrl.op = OP_IRQ;
    else if (callEn)  ctrl.op = OP_CALL;
    else if (jumpEn)  ctrl.op = OP_JUMP;
    else if (anyRet)  ctrl.op = OP_RET;
    else if (lowWrEn) ctrl.op = OP_LOWWR;
    else if (stepEn)  ctrl.op = OP_STEP;
    ctrl.push = (ctrl.op == OP_IRQ) || (ctrl.op == OP_CALL);
    ctrl.pop  = (ctrl.op == OP_RET);
  end
endmodule

// File: rtl/pc_stack.sv
module pc_stack
  import pc_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            push,
  input  logic            pop,
  input  logic [PC_W-1:0] pushData,
  output logic [PC_W-1:0] popData
);
  localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SP_W-1:0] spReg;
  logic [SP_W-1:0] topIdx;
  logic [PC_W-1:0] entry [DEPTH];

  assign topIdx  = spReg - SP_W'(1);
  assign popData = entry[topIdx];

  always_ff @(posedge clk) begin
    if (!rstN)     spReg <= '0;
    else if (push) spReg <= spReg + SP_W'(1);
    else if (pop)  spReg <= topIdx;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN)                               entry[i] <= '0;
      else if (push && spReg == SP_W'(i))      entry[i] <= pushData;
    end
  end

  // R8: a push advances the ring pointer by one, wrapping silently
  assert_push_ptr_R8: assert property (@(posedge clk) disable iff (!rstN)
    push |=> spReg == SP_W'($past(spReg) + SP_W'(1)));
  // R9: a pop retreats the ring pointer by one, wrapping below zero
  assert_pop_ptr_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !push) |=> spReg == SP_W'($past(spReg) - SP_W'(1)));
  // R5: the value just pushed is what the next pop would return
  assert_push_top_R5: assert property (@(posedge clk) disable iff (!rstN)
    push |=> popData == $past(pushData));
endmodule

// File: rtl/pc_datapath.sv
module pc_datapath
  import pc_pkg::*;
#(
  parameter logic [PC_W-1:0] RESET_VEC = '0,
  parameter logic [PC_W-1:0] IRQ_VEC   = PC_W'(4)
) (
  input  logic               clk,
  input  logic               rstN,
  input  pcCtrl_t            ctrl,
  input  logic [LOW_W-1:0]   lowWrData,
  input  logic [LATCH_W-1:0] latchWrData,
  input  logic [TGT_W-1:0]   jumpTarget,
  input  logic [PC_W-1:0]    popData,
  output logic [PC_W-1:0]    pcReg,
  output logic [PC_W-1:0]    pushData
);
  localparam int PAGE_W = PC_W - TGT_W;

  logic [LATCH_W-1:0] latchReg;
  logic [PC_W-1:0]    pcNext;
  logic [PC_W-1:0]    pagedTarget;

  assign pushData    = pcReg + PC_W'(1);
  assign pagedTarget = {latchReg[LATCH_W-1 -: PAGE_W], jumpTarget};

  always_comb begin
    case (ctrl.op)
      OP_STEP:         pcNext = pcReg + PC_W'(1);
      OP_LOWWR:        pcNext = {latchReg, lowWrData};
      OP_JUMP,
      OP_CALL:         pcNext = pagedTarget;
      OP_IRQ:          pcNext = IRQ_VEC;
      OP_RET:          pcNext = popData;
      default:         pcNext = pcReg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcReg    <= RESET_VEC;
      latchReg <= '0;
    end else begin
      pcReg <= pcNext;
      if (ctrl.latchWr) latchReg <= latchWrData;
    end
  end

  // R10: with no action selected the counter keeps its value
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.op == OP_HOLD) |=> $stable(pcReg));
  // R2: a step moves the counter to the following word
  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.op == OP_STEP) |=> pcReg == PC_W'($past(pcReg) + PC_W'(1)));
  // R6: interrupt entry lands on the interrupt vector
  assert_irq_vec_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.op == OP_IRQ) |=> pcReg == IRQ_VEC);
  // R4: jumps and calls take their page bits from the latch
  assert_jump_page_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.op == OP_JUMP || ctrl.op == OP_CALL)
      |=> pcReg[PC_W-1 -: PAGE_W] == $past(latchReg[LATCH_W-1 -: PAGE_W]));
  // R7: stack traffic leaves the page latch alone
  assert_latch_keep_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((ctrl.push || ctrl.pop) && !ctrl.latchWr) |=> $stable(latchReg));
endmodule

// File: rtl/page_pc_unit.sv
module page_pc_unit
  import pc_pkg::*;
#(
  parameter int IMPL_WORDS  = 1024,
  parameter int STACK_DEPTH = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                stepEn,
  input  logic                lowWrEn,
  input  logic [7:0]          lowWrData,
  input  logic                latchWrEn,
  input  logic [4:0]          latchWrData,
  input  logic                jumpEn,
  input  logic                callEn,
  input  logic [10:0]         jumpTarget,
  input  logic                irqEn,
  input  logic                retPlainEn,
  input  logic                retValueEn,
  input  logic                retIrqEn,
  output logic [12:0]         fetchAddr,
  output logic [7:0]          pcLow
);
  localparam logic [PC_W-1:0] ADDR_MASK = PC_W'(IMPL_WORDS - 1);

  pcCtrl_t         ctrl;
  logic [PC_W-1:0] pcReg;
  logic [PC_W-1:0] pushData;
  logic [PC_W-1:0] popData;

  pc_ctrl u_ctrl (
    .stepEn    (stepEn),
    .lowWrEn   (lowWrEn),
    .latchWrEn (latchWrEn),
    .jumpEn    (jumpEn),
    .callEn    (callEn),
    .irqEn     (irqEn),
    .retPlainEn(retPlainEn),
    .retValueEn(retValueEn),
    .retIrqEn  (retIrqEn),
    .ctrl      (ctrl)
  );

  pc_datapath u_path (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .lowWrData  (lowWrData),
    .latchWrData(latchWrData),
    .jumpTarget (jumpTarget),
    .popData    (popData),
    .pcReg      (pcReg),
    .pushData   (pushData)
  );

  pc_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk     (clk),
    .rstN    (rstN),
    .push    (ctrl.push),
    .pop     (ctrl.pop),
    .pushData(pushData),
    .popData (popData)
  );

  assign fetchAddr = pcReg & ADDR_MASK;
  assign pcLow     = pcReg[7:0];
endmodule

// File: tb/page_pc_unit_tb.sv
module page_pc_unit_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        stepEn, lowWrEn, latchWrEn, jumpEn, callEn, irqEn;
  logic        retPlainEn, retValueEn, retIrqEn;
  logic [7:0]  lowWrData;
  logic [4:0]  latchWrData;
  logic [10:0] jumpTarget;
  logic [12:0] fetchAddr;
  logic [7:0]  pcLow;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic [12:0] mPc;
  logic [4:0]  mLatch;
  logic [12:0] mStack [8];
  logic [2:0]  mSp;

  always #4 clk = ~clk;

  page_pc_unit u_dut (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .lowWrEn(lowWrEn),
    .lowWrData(lowWrData), .latchWrEn(latchWrEn), .latchWrData(latchWrData),
    .jumpEn(jumpEn), .callEn(callEn), .jumpTarget(jumpTarget), .irqEn(irqEn),
    .retPlainEn(retPlainEn), .retValueEn(retValueEn), .retIrqEn(retIrqEn),
    .fetchAddr(fetchAddr), .pcLow(pcLow)
  );

  function automatic logic [12:0] maskAddr(input logic [12:0] a);
    return a & 13'h03FF;
  endfunction

  task automatic clearIn();
    stepEn = 0; lowWrEn = 0; latchWrEn = 0; jumpEn = 0; callEn = 0; irqEn = 0;
    retPlainEn = 0; retValueEn = 0; retIrqEn = 0;
    lowWrData = '0; latchWrData = '0; jumpTarget = '0;
  endtask

  task automatic modelStep();
    logic [12:0] nxt;
    nxt = mPc;
    if (irqEn) begin
      mStack[mSp] = mPc + 13'd1; mSp = mSp + 3'd1; nxt = 13'h0004;
    end else if (callEn) begin
      mStack[mSp] = mPc + 13'd1; mSp = mSp + 3'd1; nxt = {mLatch[4:3], jumpTarget};
    end else if (jumpEn) begin
      nxt = {mLatch[4:3], jumpTarget};
    end else if (retPlainEn || retValueEn || retIrqEn) begin
      mSp = mSp - 3'd1; nxt = mStack[mSp];
    end else if (lowWrEn) begin
      nxt = {mLatch, lowWrData};
    end else if (stepEn) begin
      nxt = mPc + 13'd1;
    end
    if (latchWrEn) mLatch = latchWrData;
    mPc = nxt;
  endtask

  task automatic check(input string tag);
    checks++;
    if (fetchAddr !== maskAddr(mPc) || pcLow !== mPc[7:0]) begin
      errors++;
      $display("FAIL %s: fetchAddr=%h pcLow=%h expected fetchAddr=%h pcLow=%h",
               tag, fetchAddr, pcLow, maskAddr(mPc), mPc[7:0]);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    check(tag);
    clearIn();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    clearIn();
    rstN = 0;
    mPc = 0; mLatch = 0; mSp = 0;
    for (int i = 0; i < 8; i++) mStack[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    check("R1 reset vector");

    // R11 latch load, counter holds (R10)
    latchWrEn = 1; latchWrData = 5'b10110; tick("R11/R10 latch load, hold");
    // R3 low-byte write uses latch
    lowWrEn = 1; lowWrData = 8'h5A; tick("R3 low write");
    // R4 jump takes latch[4:3]
    jumpEn = 1; jumpTarget = 11'h123; tick("R4 jump page");
    // R2 wrap at implemented boundary
    latchWrEn = 1; latchWrData = 5'h03; tick("R10 hold during latch load");
    lowWrEn = 1; lowWrData = 8'hFF; tick("R3 low write to 0x3FF");
    stepEn = 1; tick("R2 wrap to 0x000");
    stepEn = 1; tick("R2 step");
    // R5 call, R6 irq, R7 return forms
    jumpEn = 1; jumpTarget = 11'h040; tick("R4 jump");
    callEn = 1; jumpTarget = 11'h200; tick("R5 call");
    irqEn = 1; tick("R6 irq vector");
    retIrqEn = 1; tick("R7 return from irq");
    retPlainEn = 1; tick("R7 plain return");
    jumpEn = 1; jumpTarget = 11'h011; tick("R7 latch kept after pushes/pops");
    callEn = 1; jumpTarget = 11'h300; tick("R5 call");
    retValueEn = 1; tick("R7 value return");

    // R8 ten pushes, eight pops
    for (int i = 0; i < 10; i++) begin
      callEn = 1; jumpTarget = 11'(16 * i + 5); tick("R8 push");
    end
    for (int i = 0; i < 8; i++) begin
      retPlainEn = 1; tick("R8 LIFO pop");
    end
    // R9 underflow pops
    for (int i = 0; i < 3; i++) begin
      retValueEn = 1; tick("R9 underflow pop");
    end

    // R10 priority combinations
    irqEn = 1; callEn = 1; jumpEn = 1; stepEn = 1; tick("R10 irq over call");
    callEn = 1; jumpEn = 1; retPlainEn = 1; jumpTarget = 11'h0AA; tick("R10 call over jump");
    jumpEn = 1; retIrqEn = 1; lowWrEn = 1; jumpTarget = 11'h155; tick("R10 jump over return");
    retPlainEn = 1; lowWrEn = 1; stepEn = 1; tick("R10 return over low write");
    lowWrEn = 1; stepEn = 1; lowWrData = 8'h33; latchWrEn = 1; latchWrData = 5'h1F;
    tick("R10/R3 low write over step, old latch used");
    tick("R10 idle hold");

    // random mix
    for (int i = 0; i < 1500; i++) begin
      int sel;
      sel = int'($urandom_range(0, 99));
      lowWrData   = 8'($urandom);
      latchWrData = 5'($urandom);
      jumpTarget  = 11'($urandom);
      latchWrEn   = ($urandom_range(0, 7) == 0);
      if (sel < 40)      stepEn = 1;
      else if (sel < 48) lowWrEn = 1;
      else if (sel < 56) jumpEn = 1;
      else if (sel < 66) callEn = 1;
      else if (sel < 70) irqEn = 1;
      else if (sel < 75) retPlainEn = 1;
      else if (sel < 80) retValueEn = 1;
      else if (sel < 85) retIrqEn = 1;
      else if (sel < 93) begin
        stepEn = 1'($urandom); lowWrEn = 1'($urandom); jumpEn = 1'($urandom);
        callEn = 1'($urandom); retPlainEn = 1'($urandom); irqEn = 1'($urandom);
      end
      tick("R2-mix random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule